// File: doc/BRIEF.md
# Serial Bit-Addressed Memory Front End

This block is the serial access core of a secure memory card. A bit-granular address counter advances by one on every rising edge of the card clock and is forced back to zero while the card reset input is high. The counter position is decoded into a zone code through a fixed, irregular map of 1600 bit positions. The zone code, the value of the addressed bit and a pair of write and erase strobes are passed to the surrounding security logic, which decides the access rules.

The program input sets the direction of the data pin. With the program input low, the pin is an output, and each falling card-clock edge drives the addressed bit onto it. With the program input high, the pin is an input. The bit sampled on a rising card-clock edge then requests a program operation on the current address: 0 writes the bit to 0, and 1 erases it to 1. The stored bits live in a behavioural word-organised array that initialises to all ones. A fixed busy window of `PROG_CYCLES` system clocks stands in for the self-timed programming cycle.

All inputs are synchronous to the system clock `clk`. The card clock is edge-detected against its value one system clock earlier.

Top module: `serial_mem_front`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `bit_addr` is 0, `zone` is 0, `busy`, `wr_stb` and `er_stb` are 0, and `dio_oe` and `dio_out` are 1.
- R2: Each rising `card_clk` edge seen while `card_rst` is low adds one to `bit_addr`. While `card_rst` is high, `bit_addr` is held at 0, and `bit_addr` changes at no other time.
- R3: A step taken from bit address 1599 returns `bit_addr` to 0.
- R4: `zone` reports the decoded region of `bit_addr`, using these codes: 0 = 0–15, 1 = 16–79, 2 = 80–95, 3 = 96–111, 4 = 112–175, 5 (application 1) = 176–431, 6 = 432–479, 7 (application 2) = 480–735, 8 = 736–767, 9 = 768–895, 10 = 896–911, 11 = 912–975, 12 = 992–1007, 13 = 1012–1015, 14 = 1016–1019, 15 = 1020–1023, 16 (application 3) = 1024–1535, 17 = 1536–1583, 18 = 1584. Code 19 means unused and covers 976–991, 1008–1011 and 1585–1599.
- R5: If the address has been held for at least three clocks, a falling `card_clk` edge with `pgm` low drives the stored bit at `bit_addr` onto `dio_out`. `cur_bit` carries the same value. A bit that has never been written reads as 1.
- R6: `dio_oe` is the inverse of `pgm` as registered one clock earlier.
- R7: A rising `card_clk` edge with `pgm` high and `dio_in` = 0 clears only the addressed bit to 0, and `wr_stb` pulses for one clock.
- R8: A rising edge with `pgm` high and `dio_in` = 1 in any zone other than 5, 7, 16 or 19 sets all 16 bits of the aligned word holding the address to 1, and `er_stb` pulses for one clock.
- R9: The same erase request inside zone 5, 7 or 16 sets only the addressed bit to 1 and leaves its neighbours in the word unchanged.
- R10: In the unused zone, program requests raise no strobe and change nothing, and reads return 1.
- R11: An accepted request holds `busy` high for exactly `PROG_CYCLES` clocks. A request made while `busy` is high is dropped with no strobe and no change to the array. `wr_stb` and `er_stb` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| card_clk | input | 1 | Serial card clock, edge-detected |
| card_rst | input | 1 | Address reset, high forces the counter to 0 |
| pgm | input | 1 | Direction select: 1 = pin is input (program), 0 = output |
| dio_in | input | 1 | Data pin input value |
| dio_out | output | 1 | Data pin output value |
| dio_oe | output | 1 | Data pin output enable |
| bit_addr | output | 11 | Current bit address |
| zone | output | 5 | Decoded zone code |
| cur_bit | output | 1 | Stored value of the addressed bit |
| wr_stb | output | 1 | One-clock pulse on an accepted write |
| er_stb | output | 1 | One-clock pulse on an accepted erase |
| busy | output | 1 | Program window active |

## Verification
A full walk over all 1600 positions compares the zone code against an independent decode of the map and ends at the wrap back to zero. Paired write-then-erase sequences in the issuer region and in application zone 1 use two bits of the same word. This separates word-wide erase from single-bit erase and shows that a write touches only its own bit. Requests aimed at unused positions, and a second request issued inside the busy window, must produce neither a strobe nor a stored change. These cases distinguish proper gating from an array that simply happens to hold ones.

// File: rtl/smf_pkg.sv
package smf_pkg;

  typedef enum logic [4:0] {
    ZN_FAB        = 5'd0,
    ZN_ISSUER     = 5'd1,
    ZN_SECCODE    = 5'd2,
    ZN_ATTEMPTS   = 5'd3,
    ZN_PROTECTED  = 5'd4,
    ZN_APP1       = 5'd5,
    ZN_KEY1       = 5'd6,
    ZN_APP2       = 5'd7,
    ZN_KEY2       = 5'd8,
    ZN_ERCNT2     = 5'd9,
    ZN_TEST       = 5'd10,
    ZN_MAKER      = 5'd11,
    ZN_ISS_FUSE   = 5'd12,
    ZN_FAB_FUSE   = 5'd13,
    ZN_MAKER_FUSE = 5'd14,
    ZN_CNT_FUSE   = 5'd15,
    ZN_APP3       = 5'd16,
    ZN_KEY3       = 5'd17,
    ZN_ERASE_BIT  = 5'd18,
    ZN_UNUSED     = 5'd19
  } zone_e;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_MODIFY,
    PS_HOLD
  } prog_state_e;

endpackage

// File: rtl/smf_zone_map.sv
module smf_zone_map #(
  parameter int AW = 11
) (
  input  logic [AW-1:0]   addr,
  output smf_pkg::zone_e  zone
);
  import smf_pkg::*;

  int unsigned a;

  always_comb begin
    a = 32'(addr);
    if      (a < 16)   zone = ZN_FAB;
    else if (a < 80)   zone = ZN_ISSUER;
    else if (a < 96)   zone = ZN_SECCODE;
    else if (a < 112)  zone = ZN_ATTEMPTS;
    else if (a < 176)  zone = ZN_PROTECTED;
    else if (a < 432)  zone = ZN_APP1;
    else if (a < 480)  zone = ZN_KEY1;
    else if (a < 736)  zone = ZN_APP2;
    else if (a < 768)  zone = ZN_KEY2;
    else if (a < 896)  zone = ZN_ERCNT2;
    else if (a < 912)  zone = ZN_TEST;
    else if (a < 976)  zone = ZN_MAKER;
    else if (a < 992)  zone = ZN_UNUSED;
    else if (a < 1008) zone = ZN_ISS_FUSE;
    else if (a < 1012) zone = ZN_UNUSED;
    else if (a < 1016) zone = ZN_FAB_FUSE;
    else if (a < 1020) zone = ZN_MAKER_FUSE;
    else if (a < 1024) zone = ZN_CNT_FUSE;
    else if (a < 1536) zone = ZN_APP3;
    else if (a < 1584) zone = ZN_KEY3;
    else if (a < 1585) zone = ZN_ERASE_BIT;
    else               zone = ZN_UNUSED;
  end

endmodule

// File: rtl/smf_addr_ctr.sv
module smf_addr_ctr #(
  parameter int NBITS = 1600,
  localparam int AW = $clog2(NBITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_zero,
  input  logic          step,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(NBITS - 1);

  always_ff @(posedge clk) begin
    if (rst || hold_zero) begin
      addr <= '0;
    end else if (step) begin
      addr <= (addr == LAST) ? '0 : addr + AW'(1);
    end
  end

endmodule

// File: rtl/smf_bit_store.sv
module smf_bit_store #(
  parameter int NBITS       = 1600,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 20,
  localparam int AW    = $clog2(NBITS),
  localparam int BA    = $clog2(WORD_W),
  localparam int WA    = AW - BA,
  localparam int WORDS = (NBITS + WORD_W - 1) / WORD_W,
  localparam int CW    = $clog2(PROG_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          start,
  input  logic          op_erase,
  input  logic          word_erase,
  output logic          busy,
  output logic          bit_val,
  output logic          rd_valid
);
  import smf_pkg::*;

  logic [WORD_W-1:0] mem [WORDS];
  logic [WORD_W-1:0] rd_data;
  logic [WORD_W-1:0] new_word;
  logic [WA-1:0]     rd_word;
  logic [BA-1:0]     rd_bit_q;
  logic [WA-1:0]     op_word;
  logic [BA-1:0]     op_bit;
  logic              op_er_q;
  logic              op_wide_q;
  logic [CW-1:0]     hold_cnt;
  prog_state_e       state;

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '1;
  end

  assign busy    = (state != PS_IDLE);
  assign rd_word = (state == PS_IDLE) ? addr[AW-1:BA] : op_word;
  assign bit_val = rd_data[rd_bit_q];

  // Synchronous read port
  always_ff @(posedge clk) begin
    rd_data  <= mem[rd_word];
    rd_bit_q <= addr[BA-1:0];
  end

  // Synchronous write port
  always_ff @(posedge clk) begin
    if (state == PS_MODIFY) mem[op_word] <= new_word;
  end

  always_comb begin
    new_word = rd_data;
    if (!op_er_q)       new_word[op_bit] = 1'b0;
    else if (op_wide_q) new_word = '1;
    else                new_word[op_bit] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PS_IDLE;
      hold_cnt  <= '0;
      op_word   <= '0;
      op_bit    <= '0;
      op_er_q   <= 1'b0;
      op_wide_q <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= (state == PS_IDLE);
      case (state)
        PS_IDLE: begin
          if (start) begin
            op_word   <= addr[AW-1:BA];
            op_bit    <= addr[BA-1:0];
            op_er_q   <= op_erase;
            op_wide_q <= word_erase;
            state     <= PS_MODIFY;
          end
        end
        PS_MODIFY: begin
          hold_cnt <= CW'(PROG_CYCLES - 2);
          state    <= PS_HOLD;
        end
        default: begin
          if (hold_cnt == '0) state <= PS_IDLE;
          else                hold_cnt <= hold_cnt - CW'(1);
        end
      endcase
    end
  end

endmodule

// File: rtl/serial_mem_front.sv
module serial_mem_front #(
  parameter int NBITS       = 1600,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 20,
  localparam int AW = $clog2(NBITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          card_clk,
  input  logic          card_rst,
  input  logic          pgm,
  input  logic          dio_in,
  output logic          dio_out,
  output logic          dio_oe,
  output logic [AW-1:0] bit_addr,
  output logic [4:0]    zone,
  output logic          cur_bit,
  output logic          wr_stb,
  output logic          er_stb,
  output logic          busy
);
  import smf_pkg::*;

  logic   card_clk_q;
  logic   step;
  logic   fall;
  logic   accept;
  logic   is_app;
  logic   bit_val;
  logic   rd_valid;
  zone_e  zone_now;

  assign step   = card_clk & ~card_clk_q;
  assign fall   = ~card_clk & card_clk_q;
  assign is_app = (zone_now == ZN_APP1) || (zone_now == ZN_APP2) ||
                  (zone_now == ZN_APP3);
  assign accept = step & pgm & ~card_rst & ~busy & (zone_now != ZN_UNUSED);

  smf_addr_ctr #(.NBITS(NBITS)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .hold_zero (card_rst),
    .step      (step),
    .addr      (bit_addr)
  );

  smf_zone_map #(.AW(AW)) u_map (
    .addr (bit_addr),
    .zone (zone_now)
  );

  smf_bit_store #(
    .NBITS       (NBITS),
    .WORD_W      (WORD_W),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .addr       (bit_addr),
    .start      (accept),
    .op_erase   (dio_in),
    .word_erase (dio_in & ~is_app),
    .busy       (busy),
    .bit_val    (bit_val),
    .rd_valid   (rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      card_clk_q <= 1'b0;
      zone       <= '0;
      wr_stb     <= 1'b0;
      er_stb     <= 1'b0;
      dio_oe     <= 1'b1;
      dio_out    <= 1'b1;
      cur_bit    <= 1'b1;
    end else begin
      card_clk_q <= card_clk;
      zone       <= zone_now;
      wr_stb     <= accept & ~dio_in;
      er_stb     <= accept & dio_in;
      dio_oe     <= ~pgm;
      if (rd_valid && !busy) cur_bit <= bit_val | (zone_now == ZN_UNUSED);
      if (fall && !pgm)      dio_out <= cur_bit;
    end
  end

endmodule

// File: rtl/smf_checker.sv
module smf_checker #(
  parameter int NBITS       = 1600,
  parameter int PROG_CYCLES = 20,
  localparam int AW = $clog2(NBITS),
  localparam int RW = $clog2(PROG_CYCLES + 2) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          card_rst,
  input logic          step,
  input logic          pgm,
  input logic [AW-1:0] bit_addr,
  input logic [4:0]    zone_now,
  input logic          wr_stb,
  input logic          er_stb,
  input logic          busy,
  input logic          dio_oe
);
  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + RW'(1);
    else           run_len <= '0;
  end

  assert_zero_R2: assert property (@(posedge clk) disable iff (rst)
    card_rst |=> bit_addr == '0);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!card_rst && !step) |=> $stable(bit_addr));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (!card_rst && step && bit_addr == AW'(NBITS - 1)) |=> bit_addr == '0);

  assert_dir_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> dio_oe == !$past(pgm));

  assert_unused_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_stb || er_stb) |-> $past(zone_now) != smf_pkg::ZN_UNUSED);

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && er_stb));

  assert_stb_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_stb || er_stb) |-> busy);

  assert_busy_len_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_len == RW'(PROG_CYCLES));

  assert_busy_cap_R11: assert property (@(posedge clk) disable iff (rst)
    run_len <= RW'(PROG_CYCLES));

endmodule

bind serial_mem_front smf_checker #(
  .NBITS       (NBITS),
  .PROG_CYCLES (PROG_CYCLES)
) u_smf_checker (
  .clk      (clk),
  .rst      (rst),
  .card_rst (card_rst),
  .step     (step),
  .pgm      (pgm),
  .bit_addr (bit_addr),
  .zone_now (zone_now),
  .wr_stb   (wr_stb),
  .er_stb   (er_stb),
  .busy     (busy),
  .dio_oe   (dio_oe)
);

// File: tb/test_serial_mem_front.sv
module test_serial_mem_front;
  localparam int NBITS = 1600;
  localparam int PROG  = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        card_clk = 1'b0;
  logic        card_rst = 1'b0;
  logic        pgm = 1'b0;
  logic        dio_in = 1'b0;
  logic        dio_out, dio_oe, cur_bit, wr_stb, er_stb, busy;
  logic [10:0] bit_addr;
  logic [4:0]  zone;

  int checks = 0;
  int errors = 0;
  int nwr = 0, ner = 0, run = 0, last_run = 0;

  always #10 clk = ~clk;

  serial_mem_front #(.NBITS(NBITS), .WORD_W(16), .PROG_CYCLES(PROG)) i_serial_mem_front (
    .clk(clk), .rst(rst), .card_clk(card_clk), .card_rst(card_rst), .pgm(pgm),
    .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe), .bit_addr(bit_addr),
    .zone(zone), .cur_bit(cur_bit), .wr_stb(wr_stb), .er_stb(er_stb), .busy(busy)
  );

  always @(negedge clk) begin
    if (wr_stb) nwr++;
    if (er_stb) ner++;
    if (busy) run++;
    else begin
      if (run != 0) last_run = run;
      run = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_zone(input int a);
    if (a < 16)   return 0;
    if (a < 80)   return 1;
    if (a < 96)   return 2;
    if (a < 112)  return 3;
    if (a < 176)  return 4;
    if (a < 432)  return 5;
    if (a < 480)  return 6;
    if (a < 736)  return 7;
    if (a < 768)  return 8;
    if (a < 896)  return 9;
    if (a < 912)  return 10;
    if (a < 976)  return 11;
    if (a < 992)  return 19;
    if (a < 1008) return 12;
    if (a < 1012) return 19;
    if (a < 1016) return 13;
    if (a < 1020) return 14;
    if (a < 1024) return 15;
    if (a < 1536) return 16;
    if (a < 1584) return 17;
    if (a < 1585) return 18;
    return 19;
  endfunction

  task automatic pulse();
    @(negedge clk) card_clk = 1'b1;
    repeat (4) @(negedge clk);
    card_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic home();
    card_rst = 1'b1;
    pulse();
    card_rst = 1'b0;
  endtask

  task automatic goto_addr(input int a);
    home();
    repeat (a) pulse();
  endtask

  task automatic read_at(input int a, output int v);
    goto_addr(a);
    v = int'(dio_out);
  endtask

  task automatic prog_at(input int a, input logic d);
    goto_addr(a);
    pgm = 1'b1;
    dio_in = d;
    pulse();
    pgm = 1'b0;
    dio_in = 1'b0;
    repeat (PROG + 4) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check("R1 bit_addr in reset", int'(bit_addr), 0);
    check("R1 busy in reset", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 bit_addr", int'(bit_addr), 0);
    check("R1 zone", int'(zone), 0);
    check("R1 strobes", int'(wr_stb | er_stb), 0);
    check("R1 dio_oe", int'(dio_oe), 1);
    check("R1 dio_out", int'(dio_out), 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_count();
    home();
    check("R2 zero after card reset", int'(bit_addr), 0);
    repeat (5) pulse();
    check("R2 five steps", int'(bit_addr), 5);
    repeat (6) @(negedge clk);
    check("R2 stable without edge", int'(bit_addr), 5);
    card_rst = 1'b1;
    pulse();
    check("R2 held zero during card reset", int'(bit_addr), 0);
    card_rst = 1'b0;
  endtask

  task automatic t_zones_wrap();
    home();
    for (int a = 0; a < NBITS; a++) begin
      check($sformatf("R4 zone at %0d", a), int'(zone), ref_zone(a));
      if (a == NBITS - 1) check("R3 at last address", int'(bit_addr), NBITS - 1);
      pulse();
    end
    check("R3 wrapped to zero", int'(bit_addr), 0);
  endtask

  task automatic t_dir();
    @(negedge clk) pgm = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 input mode oe", int'(dio_oe), 0);
    pgm = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 output mode oe", int'(dio_oe), 1);
  endtask

  task automatic t_read_fresh();
    int v;
    read_at(100, v);
    check("R5 fresh bit reads one", v, 1);
    check("R5 cur_bit fresh", int'(cur_bit), 1);
  endtask

  task automatic t_write();
    int v, n0;
    n0 = nwr;
    prog_at(20, 1'b0);
    check("R7 one write strobe", nwr - n0, 1);
    check("R11 busy window length", last_run, PROG);
    read_at(20, v);
    check("R7 written bit", v, 0);
    check("R5 cur_bit follows store", int'(cur_bit), 0);
    read_at(21, v);
    check("R7 neighbour untouched", v, 1);
  endtask

  task automatic t_word_erase();
    int v, n0;
    prog_at(21, 1'b0);
    read_at(21, v);
    check("R7 second bit written", v, 0);
    n0 = ner;
    prog_at(21, 1'b1);
    check("R8 one erase strobe", ner - n0, 1);
    read_at(20, v);
    check("R8 word mate erased", v, 1);
    read_at(21, v);
    check("R8 addressed bit erased", v, 1);
  endtask

  task automatic t_app_erase();
    int v;
    prog_at(200, 1'b0);
    prog_at(201, 1'b0);
    prog_at(200, 1'b1);
    read_at(200, v);
    check("R9 addressed bit erased", v, 1);
    read_at(201, v);
    check("R9 word mate kept", v, 0);
  endtask

  task automatic t_unused();
    int v, n0, e0;
    n0 = nwr;
    e0 = ner;
    prog_at(980, 1'b0);
    prog_at(1590, 1'b1);
    check("R10 no write strobe", nwr - n0, 0);
    check("R10 no erase strobe", ner - e0, 0);
    check("R10 no busy", int'(busy), 0);
    read_at(980, v);
    check("R10 read one at 980", v, 1);
    read_at(1599, v);
    check("R10 read one at 1599", v, 1);
  endtask

  task automatic t_busy_drop();
    int v, n0;
    n0 = nwr;
    goto_addr(300);
    pgm = 1'b1;
    dio_in = 1'b0;
    pulse();
    check("R11 busy after accept", int'(busy), 1);
    pulse();
    pgm = 1'b0;
    repeat (PROG + 4) @(negedge clk);
    check("R11 dropped request no strobe", nwr - n0, 1);
    read_at(300, v);
    check("R11 accepted bit", v, 0);
    read_at(301, v);
    check("R11 dropped bit unchanged", v, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_count();
    t_zones_wrap();
    t_dir();
    t_read_fresh();
    t_write();
    t_word_erase();
    t_app_erase();
    t_unused();
    t_busy_drop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule